// File: doc/BRIEF.md
# Single-Word Target-Bus Initiator

This block is the initiator end of a simple synchronous target bus with a 32-bit data path. A local user presents one request at a time over a valid/ready handshake. Each request carries a 3-bit cycle command, a byte address, write data and an active-high byte mask. The block turns the request into exactly one bus cycle. It drives a request strobe, a word address, active-low byte enables, the command and the write data. It then waits for the target's acknowledge.

A cycle ends on a rising clock edge where request and acknowledge are both sampled high. Every bus output comes straight from a flip-flop, so no output depends combinationally on acknowledge or on read data. A new user request is taken in the same clock in which the outstanding cycle completes, so back-to-back cycles run at one transfer per clock and request stays high between them. When a read cycle completes, the returned word is latched into a response register and a one-clock valid pulse is raised on the user side.

Top module: `tbusInitiator`

## Requirements
- R1: While `rstN` is low, `busReq` and `rspValid` are low and `usrReady` is high. Assertion of `rstN` drops `busReq` at once, without waiting for a clock edge.
- R2: At the edge where `usrValid` and `usrReady` are both high, the request is accepted. From the next clock, `busReq` is high, `busAddr` equals `usrAddr[15:2]`, `busCmd` equals `usrCmd` and `busWdata` equals `usrWdata`.
- R3: The byte enables are active low: `busNbe[i]` is the inverse of `usrMask[i]`, and bit i qualifies data bits [8i+7:8i].
- R4: While `busReq` is high and no completion has been sampled, `busAddr`, `busNbe`, `busCmd` and `busWdata` keep their values.
- R5: `busReq` goes from high to low only in the clock after an edge that sampled `busReq` and `busAck` both high. It stays high for as long as `busAck` is low.
- R6: `usrReady` is high when `busReq` is low or `busAck` is high. A request accepted in the completing clock keeps `busReq` high and starts the next cycle with no idle clock.
- R7: A completion with `busCmd[2]` = 1 (command 100 IO read, 101 memory read, 11x program-memory read) latches `busRdata` into `rspData`. `rspValid` is high for the one clock after that edge.
- R8: A completion with `busCmd[2]` = 0 (commands 000, 001, 010, 011: waited or posted writes) raises no `rspValid` and leaves `rspData` unchanged.
- R9: `busAck` and `busRdata` are ignored while `busReq` is low. They produce no response and no change in `rspData`.
- R10: A change of `busAck` between clock edges does not change any bus output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| usrValid | input | 1 | User request present |
| usrReady | output | 1 | Request can be accepted this clock |
| usrCmd | input | 3 | Cycle command, bus encoding |
| usrAddr | input | 16 | Byte address |
| usrWdata | input | 32 | Write data |
| usrMask | input | 4 | Byte lanes in use, active high |
| rspValid | output | 1 | One-clock pulse: read data returned |
| rspData | output | 32 | Latched read data |
| busReq | output | 1 | Cycle request |
| busAddr | output | 14 | Word address, registered |
| busNbe | output | 4 | Byte enables, active low |
| busCmd | output | 3 | Cycle command |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Cycle acknowledge from target |
| busRdata | input | 32 | Read data from target |

## Verification
The bus outputs and the response are due one clock after the edge that accepts a request or completes a cycle. The bench therefore drives inputs on the falling edge and checks them on the following falling edge, after exactly one rising edge. `usrReady` is the only output that follows the current state and `busAck` within a clock. It is checked half a nanosecond after the inputs are driven. The reset check and the mid-clock acknowledge check are also sampled between edges, to show that no edge is needed for the first and that no change happens for the second.

// File: rtl/tbusPkg.sv
package tbusPkg;

  // Cycle commands on the bus; bit 2 set means a read cycle
  typedef enum logic [2:0] {
    CMD_IO_WR      = 3'b000,
    CMD_MEM_WR     = 3'b001,
    CMD_IO_PWR     = 3'b010,
    CMD_MEM_PWR    = 3'b011,
    CMD_IO_RD      = 3'b100,
    CMD_MEM_RD     = 3'b101,
    CMD_PRG_RD     = 3'b110,
    CMD_PRG_RD_ALT = 3'b111
  } busCmdE;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture a new user request into the bus registers
    logic captureRd;  // latch returned read data
  } dpStrobeT;

  function automatic logic isReadCmd(input logic [2:0] cmd);
    return cmd[2];
  endfunction

endpackage

// File: rtl/tbusInitCtrl.sv
module tbusInitCtrl
  import tbusPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     usrValid,
  input  logic     busAck,
  input  logic     pendingRead,
  output logic     usrReady,
  output logic     busReq,
  output logic     rspValid,
  output dpStrobeT strobe
);

  logic reqQ;
  logic rspQ;
  logic cycleDone;
  logic accept;

  assign cycleDone = reqQ & busAck;
  assign usrReady  = ~reqQ | busAck;
  assign accept    = usrValid & usrReady;

  always_comb begin
    strobe           = '0;
    strobe.loadReq   = accept;
    strobe.captureRd = cycleDone & pendingRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      rspQ <= 1'b0;
    end else begin
      if (accept)         reqQ <= 1'b1;
      else if (cycleDone) reqQ <= 1'b0;
      rspQ <= strobe.captureRd;
    end
  end

  assign busReq   = reqQ;
  assign rspValid = rspQ;

endmodule

// File: rtl/tbusInitDp.sv
module tbusInitDp
  import tbusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int OFS     = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFS
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobeT           strobe,
  input  logic [2:0]         usrCmd,
  input  logic [ADDR_W-1:0]  usrAddr,
  input  logic [DATA_W-1:0]  usrWdata,
  input  logic [LANES-1:0]   usrMask,
  input  logic [DATA_W-1:0]  busRdata,
  output logic [WADDR_W-1:0] busAddr,
  output logic [LANES-1:0]   busNbe,
  output logic [2:0]         busCmd,
  output logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  rspData,
  output logic               pendingRead
);

  logic [WADDR_W-1:0] addrQ;
  logic [2:0]         cmdQ;
  logic [DATA_W-1:0]  rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cmdQ  <= CMD_IO_WR;
    end else if (strobe.loadReq) begin
      addrQ <= usrAddr[ADDR_W-1:OFS];
      cmdQ  <= usrCmd;
    end
  end

  // Per-lane enable and data registers
  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic       nbeQ;
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nbeQ  <= 1'b1;
        byteQ <= '0;
      end else if (strobe.loadReq) begin
        nbeQ  <= ~usrMask[lane];
        byteQ <= usrWdata[8*lane +: 8];
      end
    end
    assign busNbe[lane]            = nbeQ;
    assign busWdata[8*lane +: 8]   = byteQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdQ <= '0;
    else if (strobe.captureRd) rdQ <= busRdata;
  end

  assign busAddr     = addrQ;
  assign busCmd      = cmdQ;
  assign rspData     = rdQ;
  assign pendingRead = isReadCmd(cmdQ);

endmodule

// File: rtl/tbusInitiator.sv
module tbusInitiator
  import tbusPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int WADDR_W = ADDR_W - $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               usrValid,
  output logic               usrReady,
  input  logic [2:0]         usrCmd,
  input  logic [ADDR_W-1:0]  usrAddr,
  input  logic [DATA_W-1:0]  usrWdata,
  input  logic [LANES-1:0]   usrMask,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData,
  output logic               busReq,
  output logic [WADDR_W-1:0] busAddr,
  output logic [LANES-1:0]   busNbe,
  output logic [2:0]         busCmd,
  output logic [DATA_W-1:0]  busWdata,
  input  logic               busAck,
  input  logic [DATA_W-1:0]  busRdata
);

  dpStrobeT strobe;
  logic     pendingRead;

  tbusInitCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .usrValid    (usrValid),
    .busAck      (busAck),
    .pendingRead (pendingRead),
    .usrReady    (usrReady),
    .busReq      (busReq),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  tbusInitDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .usrCmd      (usrCmd),
    .usrAddr     (usrAddr),
    .usrWdata    (usrWdata),
    .usrMask     (usrMask),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busNbe      (busNbe),
    .busCmd      (busCmd),
    .busWdata    (busWdata),
    .rspData     (rspData),
    .pendingRead (pendingRead)
  );

endmodule

// File: rtl/tbusInitChecker.sv
module tbusInitChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int WADDR_W = ADDR_W - $clog2(LANES)
) (
  input logic               clk,
  input logic               rstN,
  input logic               usrValid,
  input logic               usrReady,
  input logic [LANES-1:0]   usrMask,
  input logic               rspValid,
  input logic [DATA_W-1:0]  rspData,
  input logic               busReq,
  input logic [WADDR_W-1:0] busAddr,
  input logic [LANES-1:0]   busNbe,
  input logic [2:0]         busCmd,
  input logic [DATA_W-1:0]  busWdata,
  input logic               busAck,
  input logic [DATA_W-1:0]  busRdata
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (!busReq && !rspValid));

  assert_lane_enables_R3: assert property (@(posedge clk) disable iff (!rstN)
    (usrValid && usrReady) |=> (busNbe == ~$past(usrMask)));

  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> ($stable(busAddr) && $stable(busNbe) &&
                             $stable(busCmd) && $stable(busWdata)));

  assert_req_falls_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(busAck));

  assert_ready_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> usrReady);

  assert_read_response_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && busCmd[2]) |=> (rspValid && rspData == $past(busRdata)));

  assert_no_write_response_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAck && !busCmd[2]) |=> (!rspValid && $stable(rspData)));

  assert_idle_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq) |=> (!rspValid && $stable(rspData)));

endmodule

bind tbusInitiator tbusInitChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .usrValid (usrValid),
  .usrReady (usrReady),
  .usrMask  (usrMask),
  .rspValid (rspValid),
  .rspData  (rspData),
  .busReq   (busReq),
  .busAddr  (busAddr),
  .busNbe   (busNbe),
  .busCmd   (busCmd),
  .busWdata (busWdata),
  .busAck   (busAck),
  .busRdata (busRdata)
);

// File: tb/tbusInitiator_bench.sv
`timescale 1ns/100ps
module tbusInitiator_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usrValid = 1'b0;
  logic        usrReady;
  logic [2:0]  usrCmd = '0;
  logic [15:0] usrAddr = '0;
  logic [31:0] usrWdata = '0;
  logic [3:0]  usrMask = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        busReq;
  logic [13:0] busAddr;
  logic [3:0]  busNbe;
  logic [2:0]  busCmd;
  logic [31:0] busWdata;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  int tests  = 0;
  int failed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tbusInitiator u_tbusInitiator (
    .clk(clk), .rstN(rstN), .usrValid(usrValid), .usrReady(usrReady),
    .usrCmd(usrCmd), .usrAddr(usrAddr), .usrWdata(usrWdata), .usrMask(usrMask),
    .rspValid(rspValid), .rspData(rspData), .busReq(busReq), .busAddr(busAddr),
    .busNbe(busNbe), .busCmd(busCmd), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata)
  );

  // Stimulus: {valid, cmd[3], addr[16], wdata[32], mask[4], ack, rdata[32]}
  localparam int NV = 9;
  localparam logic [88:0] STIM [NV] = '{
    {1'b1, 3'b001, 16'h1234, 32'hAAAA5555, 4'hF, 1'b0, 32'h0},        // write accepted
    {1'b1, 3'b101, 16'h0040, 32'h0,        4'h3, 1'b0, 32'h0},        // blocked, no ack
    {1'b1, 3'b101, 16'h0040, 32'h0,        4'h3, 1'b1, 32'h0},        // write done, read taken (R6, R8)
    {1'b0, 3'b000, 16'h0000, 32'h0,        4'h0, 1'b1, 32'hDEADBEEF}, // read done
    {1'b0, 3'b000, 16'h0000, 32'h0,        4'h0, 1'b1, 32'h12345678}, // idle ack ignored (R9)
    {1'b1, 3'b100, 16'hFFFC, 32'h0,        4'h1, 1'b0, 32'h0},        // top address
    {1'b1, 3'b110, 16'h0008, 32'h0,        4'h8, 1'b1, 32'h11112222}, // program read behind IO read
    {1'b1, 3'b011, 16'h0100, 32'h0BADCAFE, 4'h6, 1'b1, 32'h33334444}, // posted write behind read
    {1'b0, 3'b000, 16'h0000, 32'h0,        4'h0, 1'b1, 32'h55556666}  // write done, no response (R8)
  };
  // Expected: {ready, req, addr[14], nbe[4], cmd[3], rspValid, rspData[32]}
  localparam logic [55:0] EXPV [NV] = '{
    {1'b1, 1'b1, 14'h048D, 4'h0, 3'b001, 1'b0, 32'h0},
    {1'b0, 1'b1, 14'h048D, 4'h0, 3'b001, 1'b0, 32'h0},
    {1'b1, 1'b1, 14'h0010, 4'hC, 3'b101, 1'b0, 32'h0},
    {1'b1, 1'b0, 14'h0010, 4'hC, 3'b101, 1'b1, 32'hDEADBEEF},
    {1'b1, 1'b0, 14'h0010, 4'hC, 3'b101, 1'b0, 32'hDEADBEEF},
    {1'b1, 1'b1, 14'h3FFF, 4'hE, 3'b100, 1'b0, 32'hDEADBEEF},
    {1'b1, 1'b1, 14'h0002, 4'h7, 3'b110, 1'b1, 32'h11112222},
    {1'b1, 1'b1, 14'h0040, 4'h9, 3'b011, 1'b1, 32'h33334444},
    {1'b1, 1'b0, 14'h0040, 4'h9, 3'b011, 1'b0, 32'h33334444}
  };

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [88:0] v);
    usrValid = v[88];
    usrCmd   = v[87:85];
    usrAddr  = v[84:69];
    usrWdata = v[68:37];
    usrMask  = v[36:33];
    busAck   = v[32];
    busRdata = v[31:0];
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failed++;
    tests++;
    $display("FAIL watchdog: run did not end");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "busReq in reset", busReq, 0);
    check("R1", "rspValid in reset", rspValid, 0);
    check("R1", "usrReady in reset", usrReady, 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(STIM[i]);
      #0.5;
      check("R6", $sformatf("vec %0d usrReady", i), usrReady, EXPV[i][55]);
      @(negedge clk);
      check("R5", $sformatf("vec %0d busReq", i), busReq, EXPV[i][54]);
      check("R2", $sformatf("vec %0d busAddr", i), busAddr, EXPV[i][53:40]);
      check("R3", $sformatf("vec %0d busNbe", i), busNbe, EXPV[i][39:36]);
      check("R2", $sformatf("vec %0d busCmd", i), busCmd, EXPV[i][35:33]);
      check("R7", $sformatf("vec %0d rspValid", i), rspValid, EXPV[i][32]);
      check("R7", $sformatf("vec %0d rspData", i), rspData, EXPV[i][31:0]);
      if (i == 0) check("R2", "vec 0 busWdata", busWdata, 32'hAAAA5555);
    end

    // R4, R5, R10: waited IO write held across stalls
    drive({1'b1, 3'b000, 16'h2000, 32'hCAFEF00D, 4'hF, 1'b0, 32'h0});
    @(negedge clk);
    drive({1'b0, 3'b111, 16'h0000, 32'h0, 4'h0, 1'b0, 32'h0});
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      check("R4", "held busAddr", busAddr, 14'h0800);
      check("R4", "held busWdata", busWdata, 32'hCAFEF00D);
      check("R4", "held busCmd", busCmd, 3'b000);
      check("R5", "req held while no ack", busReq, 1);
    end
    // R10: pulse ack between edges only
    #0.5 busAck = 1'b1;
    #0.5;
    check("R10", "busReq after mid-clock ack", busReq, 1);
    check("R10", "busAddr after mid-clock ack", busAddr, 14'h0800);
    busAck = 1'b0;
    @(negedge clk);
    check("R10", "busReq after dropped ack", busReq, 1);
    busAck = 1'b1;
    busRdata = 32'h77778888;
    @(negedge clk);
    check("R5", "req falls after completion", busReq, 0);
    check("R8", "no response after write", rspValid, 0);
    check("R8", "rspData kept after write", rspData, 32'h33334444);
    busAck = 1'b0;

    // R1: asynchronous reset drops a live request
    drive({1'b1, 3'b101, 16'h0010, 32'h0, 4'hF, 1'b0, 32'h0});
    @(negedge clk);
    usrValid = 1'b0;
    check("R2", "read request raised", busReq, 1);
    #1 rstN = 1'b0;
    #0.5;
    check("R1", "busReq after async reset", busReq, 0);
    check("R1", "usrReady after async reset", usrReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end

endmodule